// File: doc/BRIEF.md
# Echoing Addressed Command Frame Engine

This block is the command-decoding slave behind a byte link. A serial receiver or a parallel mailbox feeds it one byte at a time, and a transmitter takes the bytes it produces. Each received byte is sent back unchanged before the next byte is taken. The host can therefore pace itself on the echo. Bytes are grouped into frames. A frame opens with a node-name byte that has its top bit set. A command byte follows, and then the command's parameters. Each parameter is carried as two bytes, upper nibble first.

When a frame carries this node's name or the wildcard name, the block runs the command against a small register file. That register file holds one 16-bit code per output channel, two indicator bits, sticky error flags and the node's own name. If the command returns data, the reply goes out as nibble bytes right after the echo of the frame's last byte. Frames aimed at other nodes are echoed in full and otherwise ignored. The parser still counts their parameters, so it finds the start of the next frame.

Top module: `cfe_engine`

## Requirements
- R1: While the engine waits for a frame to start, a byte with bit 7 clear is echoed and otherwise ignored. A byte of 128 or more starts a frame and is taken as the name.
- R2: Every accepted byte appears unchanged as the next byte on the transmit side. `rx_ready` stays low while any output byte is still pending.
- R3: A frame is executed only if its name equals the stored name or equals 255. A frame for another node is fully echoed, sends no reply and changes no state, and the frame after it is decoded normally.
- R4: Every parameter arrives as two bytes, the upper nibble first and then the lower nibble, each in 0..15. Reply parameters leave in the same split form, immediately after the echo of the frame's last byte.
- R5: Command 16 takes a channel number in 1..NUM_CH. It replies with four nibble bytes that carry that channel's 16-bit code, most significant nibble first.
- R6: Command 17 takes a channel, a code high byte and a code low byte. It writes `{high, low}` into bits `[(ch-1)*16 +: 16]` of `chan_codes` and sends no reply.
- R7: Command 18 takes no parameters, sets every channel code to 0 and sends no reply.
- R8: Command 19 replies with the current `cfg_switch` value.
- R9: Command 20 takes two parameters, each 0 (off) or 255 (on). The first drives `led[0]` and the second drives `led[1]`. Any other value is a parameter error and leaves the LEDs unchanged.
- R10: Command 21 replies with a status byte. Bit 0 is `led[0]` and bit 1 is `led[1]`. Bit 4 is the unknown-command flag and bit 5 is the parameter-error flag. Bits 2, 3, 6 and 7 read 0. Reading the status clears bits 4 and 5.
- R11: Command 22 replies with the stored name. Command 23 takes one parameter in 128..255 and stores it as the new name. A value below 128 is a parameter error.
- R12: Command 24 replies with OPT_MASK with bits 0 and 1 forced to 1. Command 25 replies with FW_VERSION, which is ten times the version number.
- R13: In a matching frame, a command byte outside 16..25 sets status bit 4, and a parameter byte above 15 or an out-of-range parameter value sets status bit 5. Either way the frame is dropped without a reply, and the next byte is treated as a possible name.
- R14: After reset all channel codes are 0, both LEDs are off, both error flags are clear and the stored name is RESET_NAME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine accepts the offered byte this cycle |
| tx_valid | output | 1 | An output byte (echo or reply) is offered |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Transmitter takes the output byte this cycle |
| cfg_switch | input | 8 | Configuration switch value returned by command 16+3 |
| led | output | 2 | Indicator bits |
| chan_codes | output | NUM_CH*16 | Channel codes, channel 1 in the low 16 bits |

## Verification
A directed sequence walks each command once with a matching name, once with the wildcard name and once with a foreign name. It then adds a stray low byte before a frame, a nibble byte above 15, an out-of-range channel, an illegal LED value and an unknown command. These cases separate execution, silent skipping of foreign frames, and error abandonment. After them, a few hundred frames built at random mix all ten commands, all three name kinds and rare corrupted parameters. The transmitter meanwhile withholds `tx_ready` at random, which exposes any reply that overtakes an echo or any byte accepted while output is still pending. After every frame, the whole output byte stream, the LED pins and all channel codes are compared with a bench model of the requirements.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    localparam int BYTE_W          = 8;
    localparam int CODE_W          = 16;
    localparam int MAX_REPLY_BYTES = 4;
    localparam int QDEPTH          = 1 + MAX_REPLY_BYTES;
    localparam int CNT_W           = $clog2(QDEPTH + 1);

    localparam logic [7:0] NAME_ANY  = 8'd255;
    localparam logic [7:0] C_RD_CODE = 8'd16;
    localparam logic [7:0] C_WR_CODE = 8'd17;
    localparam logic [7:0] C_CLR_ALL = 8'd18;
    localparam logic [7:0] C_RD_SW   = 8'd19;
    localparam logic [7:0] C_SET_LED = 8'd20;
    localparam logic [7:0] C_RD_STAT = 8'd21;
    localparam logic [7:0] C_RD_NAME = 8'd22;
    localparam logic [7:0] C_WR_NAME = 8'd23;
    localparam logic [7:0] C_RD_MASK = 8'd24;
    localparam logic [7:0] C_RD_VER  = 8'd25;

    typedef enum logic [1:0] {P_NAME, P_CMD, P_HI, P_LO} parse_st_t;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] p0;
        logic [7:0] p1;
        logic [7:0] p2;
    } frame_t;

    function automatic logic known_cmd(input logic [7:0] c);
        return (c >= C_RD_CODE) && (c <= C_RD_VER);
    endfunction

    function automatic logic [1:0] param_count(input logic [7:0] c);
        case (c)
            C_RD_CODE: return 2'd1;
            C_WR_CODE: return 2'd3;
            C_SET_LED: return 2'd2;
            C_WR_NAME: return 2'd1;
            default:   return 2'd0;
        endcase
    endfunction

    function automatic logic switch_val(input logic [7:0] v);
        return (v == 8'd0) || (v == 8'd255);
    endfunction

    function automatic logic params_ok(input frame_t f, input int nch);
        case (f.cmd)
            C_RD_CODE, C_WR_CODE: return (f.p0 != 8'd0) && (int'(f.p0) <= nch);
            C_SET_LED:            return switch_val(f.p0) && switch_val(f.p1);
            C_WR_NAME:            return f.p0[7];
            default:              return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] nib_byte(input logic [3:0] n);
        return {4'h0, n};
    endfunction

endpackage

// File: rtl/cfe_parser.sv
module cfe_parser
    import cfe_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       take_i,
    input  logic [7:0] byte_i,
    input  logic [7:0] own_name_i,
    output logic       exec_o,
    output frame_t     frame_o,
    output logic       cmd_err_o,
    output logic       par_err_o
);

    parse_st_t  st_q, st_n;
    logic       match_q, match_n;
    logic [7:0] cmd_q, cmd_n, p0_q, p0_n, p1_q, p1_n;
    logic [1:0] idx_q, idx_n;
    logic [3:0] hi_q, hi_n;
    logic [7:0] val;
    logic [1:0] cnt;
    logic       nib_bad;

    assign val     = {hi_q, byte_i[3:0]};
    assign cnt     = param_count(cmd_q);
    assign nib_bad = byte_i[7:4] != 4'h0;

    always_comb begin
        frame_o.cmd = (st_q == P_CMD) ? byte_i : cmd_q;
        frame_o.p0  = (idx_q == 2'd0) ? val : p0_q;
        frame_o.p1  = (idx_q == 2'd1) ? val : p1_q;
        frame_o.p2  = val;
    end

    always_comb begin
        st_n = st_q; match_n = match_q; cmd_n = cmd_q; idx_n = idx_q;
        hi_n = hi_q; p0_n = p0_q; p1_n = p1_q;
        exec_o = 1'b0; cmd_err_o = 1'b0; par_err_o = 1'b0;
        if (take_i) begin
            case (st_q)
                P_NAME: if (byte_i[7]) begin
                    st_n    = P_CMD;
                    match_n = (byte_i == NAME_ANY) || (byte_i == own_name_i);
                end
                P_CMD: begin
                    cmd_n = byte_i;
                    idx_n = 2'd0;
                    if (!known_cmd(byte_i)) begin
                        cmd_err_o = match_q;
                        st_n      = P_NAME;
                    end else if (param_count(byte_i) == 2'd0) begin
                        exec_o = match_q;
                        st_n   = P_NAME;
                    end else begin
                        st_n = P_HI;
                    end
                end
                P_HI: if (nib_bad) begin
                    par_err_o = match_q;
                    st_n      = P_NAME;
                end else begin
                    hi_n = byte_i[3:0];
                    st_n = P_LO;
                end
                default: if (nib_bad) begin
                    par_err_o = match_q;
                    st_n      = P_NAME;
                end else if (idx_q == cnt - 2'd1) begin
                    if (params_ok(frame_o, NUM_CH)) exec_o = match_q;
                    else                            par_err_o = match_q;
                    st_n = P_NAME;
                end else begin
                    if (idx_q == 2'd0) p0_n = val;
                    else               p1_n = val;
                    idx_n = idx_q + 2'd1;
                    st_n  = P_HI;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= P_NAME; match_q <= 1'b0; cmd_q <= '0; idx_q <= '0;
            hi_q <= '0; p0_q <= '0; p1_q <= '0;
        end else begin
            st_q <= st_n; match_q <= match_n; cmd_q <= cmd_n; idx_q <= idx_n;
            hi_q <= hi_n; p0_q <= p0_n; p1_q <= p1_n;
        end
    end

    AST_IDLE_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        (take_i && st_q == P_NAME && !byte_i[7]) |=> (st_q == P_NAME)); // R1
    AST_NIBBLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (exec_o && st_q == P_LO) |-> (byte_i[7:4] == 4'h0)); // R4
    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q != P_NAME && !match_q) |-> !(exec_o || cmd_err_o || par_err_o)); // R3

endmodule

// File: rtl/cfe_regfile.sv
module cfe_regfile
    import cfe_pkg::*;
#(
    parameter int         NUM_CH     = 8,
    parameter logic [7:0] RESET_NAME = 8'd254,
    parameter logic [7:0] OPT_MASK   = 8'h3C,
    parameter logic [7:0] FW_VERSION = 8'd11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         exec_i,
    input  frame_t                       frame_i,
    input  logic                         cmd_err_i,
    input  logic                         par_err_i,
    input  logic [7:0]                   cfg_sw_i,
    output logic [1:0]                   led_o,
    output logic [NUM_CH*CODE_W-1:0]     codes_o,
    output logic [7:0]                   name_o,
    output logic [CNT_W-1:0]             rep_cnt_o,
    output logic [MAX_REPLY_BYTES*8-1:0] rep_bytes_o
);

    logic [CODE_W-1:0] code_q [NUM_CH];
    logic [1:0]        led_q;
    logic              err_cmd_q, err_par_q;
    logic [7:0]        name_q;
    logic [CODE_W-1:0] sel;
    logic [7:0]        status, one_val;

    assign status = {2'b00, err_par_q, err_cmd_q, 2'b00, led_q};
    assign led_o  = led_q;
    assign name_o = name_q;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_out
            assign codes_o[g*CODE_W +: CODE_W] = code_q[g];
        end
    endgenerate

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (frame_i.p0 == 8'(i + 1)) sel = code_q[i];
    end

    always_comb begin
        one_val   = 8'h00;
        rep_cnt_o = CNT_W'(2);
        case (frame_i.cmd)
            C_RD_SW:   one_val = cfg_sw_i;
            C_RD_STAT: one_val = status;
            C_RD_NAME: one_val = name_q;
            C_RD_MASK: one_val = OPT_MASK | 8'h03;
            C_RD_VER:  one_val = FW_VERSION;
            C_RD_CODE: rep_cnt_o = CNT_W'(4);
            default:   rep_cnt_o = CNT_W'(0);
        endcase
        if (frame_i.cmd == C_RD_CODE)
            rep_bytes_o = {nib_byte(sel[3:0]), nib_byte(sel[7:4]),
                           nib_byte(sel[11:8]), nib_byte(sel[15:12])};
        else
            rep_bytes_o = {16'h0000, nib_byte(one_val[3:0]), nib_byte(one_val[7:4])};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) code_q[i] <= '0;
            led_q     <= 2'b00;
            err_cmd_q <= 1'b0;
            err_par_q <= 1'b0;
            name_q    <= RESET_NAME;
        end else begin
            if (cmd_err_i) err_cmd_q <= 1'b1;
            if (par_err_i) err_par_q <= 1'b1;
            if (exec_i) begin
                case (frame_i.cmd)
                    C_WR_CODE:
                        for (int i = 0; i < NUM_CH; i++)
                            if (frame_i.p0 == 8'(i + 1)) code_q[i] <= {frame_i.p1, frame_i.p2};
                    C_CLR_ALL:
                        for (int i = 0; i < NUM_CH; i++) code_q[i] <= '0;
                    C_SET_LED: led_q <= {frame_i.p1[0], frame_i.p0[0]};
                    C_RD_STAT: begin
                        err_cmd_q <= 1'b0;
                        err_par_q <= 1'b0;
                    end
                    C_WR_NAME: name_q <= frame_i.p0;
                    default: ;
                endcase
            end
        end
    end

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (exec_i && frame_i.cmd == C_CLR_ALL) |=> (codes_o == '0)); // R7
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(exec_i && frame_i.cmd == C_SET_LED) |=> $stable(led_o)); // R9
    AST_NAME_HIGH: assert property (@(posedge clk) disable iff (rst)
        name_o[7]); // R11
    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exec_i |=> $stable(codes_o)); // R3

endmodule

// File: rtl/cfe_txq.sv
module cfe_txq
    import cfe_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push_i,
    input  logic [CNT_W-1:0]       push_cnt_i,
    input  logic [DEPTH*8-1:0]     push_data_i,
    input  logic                   tx_ready_i,
    output logic                   tx_valid_o,
    output logic [7:0]             tx_data_o,
    output logic                   empty_o
);

    logic [7:0]       buf_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             pop;

    assign empty_o    = (cnt_q == '0);
    assign tx_valid_o = !empty_o;
    assign tx_data_o  = buf_q[0];
    assign pop        = tx_valid_o && tx_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
        end else if (push_i) begin
            cnt_q <= push_cnt_i;
            for (int i = 0; i < DEPTH; i++) buf_q[i] <= push_data_i[i*8 +: 8];
        end else if (pop) begin
            cnt_q <= cnt_q - CNT_W'(1);
            for (int i = 0; i < DEPTH - 1; i++) buf_q[i] <= buf_q[i+1];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push_i |-> empty_o); // R2
    AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (rst)
        pop |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R4

endmodule

// File: rtl/cfe_engine.sv
module cfe_engine
    import cfe_pkg::*;
#(
    parameter int         NUM_CH     = 8,
    parameter logic [7:0] RESET_NAME = 8'd254,
    parameter logic [7:0] OPT_MASK   = 8'h3C,
    parameter logic [7:0] FW_VERSION = 8'd11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_data,
    output logic                     rx_ready,
    output logic                     tx_valid,
    output logic [7:0]               tx_data,
    input  logic                     tx_ready,
    input  logic [7:0]               cfg_switch,
    output logic [1:0]               led,
    output logic [NUM_CH*CODE_W-1:0] chan_codes
);

    logic                         take, q_empty, exec, cerr, perr;
    frame_t                       frm;
    logic [7:0]                   own_name;
    logic [CNT_W-1:0]             rep_cnt, push_cnt;
    logic [MAX_REPLY_BYTES*8-1:0] rep_bytes;

    assign rx_ready = q_empty;
    assign take     = rx_valid && rx_ready;
    assign push_cnt = exec ? CNT_W'(1) + rep_cnt : CNT_W'(1);

    cfe_parser #(.NUM_CH(NUM_CH)) u_parser (
        .clk(clk), .rst(rst), .take_i(take), .byte_i(rx_data),
        .own_name_i(own_name), .exec_o(exec), .frame_o(frm),
        .cmd_err_o(cerr), .par_err_o(perr)
    );

    cfe_regfile #(
        .NUM_CH(NUM_CH), .RESET_NAME(RESET_NAME),
        .OPT_MASK(OPT_MASK), .FW_VERSION(FW_VERSION)
    ) u_regs (
        .clk(clk), .rst(rst), .exec_i(exec), .frame_i(frm),
        .cmd_err_i(cerr), .par_err_i(perr), .cfg_sw_i(cfg_switch),
        .led_o(led), .codes_o(chan_codes), .name_o(own_name),
        .rep_cnt_o(rep_cnt), .rep_bytes_o(rep_bytes)
    );

    cfe_txq #(.DEPTH(QDEPTH)) u_txq (
        .clk(clk), .rst(rst), .push_i(take), .push_cnt_i(push_cnt),
        .push_data_i({rep_bytes, rx_data}), .tx_ready_i(tx_ready),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .empty_o(q_empty)
    );

    AST_ECHO_NEXT: assert property (@(posedge clk) disable iff (rst)
        take |=> (tx_valid && tx_data == $past(rx_data))); // R2
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !rx_ready); // R2

endmodule

// File: tb/tb_cfe_engine.sv
`timescale 1ns/1ps
module tb_cfe_engine;

    localparam int NCH = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready, tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b1;
    logic [7:0]        cfg_switch = 8'h00;
    logic [1:0]        led;
    logic [NCH*16-1:0] chan_codes;

    cfe_engine dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .cfg_switch(cfg_switch), .led(led),
        .chan_codes(chan_codes)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit bp_en  = 1'b0;
    bit done   = 1'b0;

    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] fr_q[$];

    // model state
    int         ms = 0;
    bit         mm = 1'b0;
    logic [7:0] mc = '0;
    int         mi = 0;
    logic [3:0] mh = '0;
    logic [7:0] mp [3];
    logic [15:0] mcode [NCH];
    logic [1:0] mled = 2'b00;
    bit         merrc = 1'b0, merrp = 1'b0;
    logic [7:0] mname = 8'd254;

    always @(negedge clk) begin
        tx_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
        if (!rst && tx_valid && tx_ready) got_q.push_back(tx_data);
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pc(input logic [7:0] c);
        case (c)
            8'd16: return 1;
            8'd17: return 3;
            8'd20: return 2;
            8'd23: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_ok();
        case (mc)
            8'd16, 8'd17: return (mp[0] >= 1) && (mp[0] <= NCH);
            8'd20: return (mp[0] == 0 || mp[0] == 255) && (mp[1] == 0 || mp[1] == 255);
            8'd23: return mp[0][7];
            default: return 1'b1;
        endcase
    endfunction

    task automatic push2(input logic [7:0] v);
        exp_q.push_back({4'h0, v[7:4]});
        exp_q.push_back({4'h0, v[3:0]});
    endtask

    task automatic m_exec();
        case (mc)
            8'd16: begin
                push2(mcode[mp[0]-1][15:8]);
                push2(mcode[mp[0]-1][7:0]);
            end
            8'd17: mcode[mp[0]-1] = {mp[1], mp[2]};
            8'd18: for (int i = 0; i < NCH; i++) mcode[i] = '0;
            8'd19: push2(cfg_switch);
            8'd20: mled = {mp[1] == 8'd255, mp[0] == 8'd255};
            8'd21: begin
                push2({2'b00, merrp, merrc, 2'b00, mled});
                merrc = 1'b0; merrp = 1'b0;
            end
            8'd22: push2(mname);
            8'd23: mname = mp[0];
            8'd24: push2(8'h3F);
            8'd25: push2(8'd11);
            default: ;
        endcase
    endtask

    task automatic model_byte(input logic [7:0] b);
        exp_q.push_back(b);
        case (ms)
            0: if (b[7]) begin ms = 1; mm = (b == 8'd255) || (b == mname); end
            1: begin
                mc = b; mi = 0;
                if (b < 16 || b > 25) begin if (mm) merrc = 1'b1; ms = 0; end
                else if (pc(b) == 0) begin if (mm) m_exec(); ms = 0; end
                else ms = 2;
            end
            2: if (b > 15) begin if (mm) merrp = 1'b1; ms = 0; end
               else begin mh = b[3:0]; ms = 3; end
            default: if (b > 15) begin if (mm) merrp = 1'b1; ms = 0; end
            else begin
                mp[mi] = {mh, b[3:0]};
                if (mi == pc(mc) - 1) begin
                    if (m_ok()) begin if (mm) m_exec(); end
                    else if (mm) merrp = 1'b1;
                    ms = 0;
                end else begin mi++; ms = 2; end
            end
        endcase
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic run_frame(input string tag);
        int t;
        foreach (fr_q[i]) begin
            model_byte(fr_q[i]);
            send_byte(fr_q[i]);
        end
        t = 0;
        while (!rx_ready && t < 200) begin @(negedge clk); t++; end
        begin
            bit same;
            logic [127:0] a, e;
            same = (got_q.size() == exp_q.size());
            a = '0; e = '0;
            foreach (exp_q[i]) begin
                if (i < got_q.size() && got_q[i] !== exp_q[i]) same = 1'b0;
                if (i < 16) e[i*8 +: 8] = exp_q[i];
            end
            foreach (got_q[i]) if (i < 16) a[i*8 +: 8] = got_q[i];
            check(same, tag, "output byte stream", a, e);
        end
        begin
            logic [NCH*16-1:0] ec;
            for (int i = 0; i < NCH; i++) ec[i*16 +: 16] = mcode[i];
            check(chan_codes === ec, tag, "chan_codes", chan_codes, ec);
            check(led === mled, tag, "led", led, mled);
        end
        got_q.delete(); exp_q.delete(); fr_q.delete();
    endtask

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'd16: return "R5";
            8'd17: return "R6";
            8'd18: return "R7";
            8'd19: return "R8";
            8'd20: return "R9";
            8'd21: return "R10";
            8'd22, 8'd23: return "R11";
            8'd24, 8'd25: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic push_param(input logic [7:0] v);
        fr_q.push_back({4'h0, v[7:4]});
        fr_q.push_back({4'h0, v[3:0]});
    endtask

    task automatic rand_frame();
        logic [7:0] nm, c;
        int k;
        k = $urandom % 3;
        nm = (k == 0) ? 8'd255 : (k == 1) ? mname : 8'(128 + $urandom % 127);
        c = (($urandom % 20) == 0) ? 8'(26 + $urandom % 100) : 8'(16 + $urandom % 10);
        fr_q.push_back(nm);
        fr_q.push_back(c);
        case (c)
            8'd16: push_param(8'(1 + $urandom % (($urandom % 10 == 0) ? 10 : NCH)));
            8'd17: begin
                push_param(8'(1 + $urandom % NCH));
                push_param(8'($urandom)); push_param(8'($urandom));
            end
            8'd20: begin
                push_param(($urandom % 2) ? 8'd255 : 8'd0);
                push_param(($urandom % 2) ? 8'd255 : 8'd0);
            end
            8'd23: push_param(8'(128 + $urandom % 128));
            default: ;
        endcase
        if (fr_q.size() > 2 && ($urandom % 25) == 0)
            fr_q[2 + $urandom % (fr_q.size() - 2)] = 8'(16 + $urandom % 200);
        cfg_switch = 8'($urandom);
        run_frame(tag_of(c));
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) mcode[i] = '0;
        for (int i = 0; i < 3; i++) mp[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        got_q.delete();
        // R14: reset state at the ports
        check(rx_ready === 1'b1, "R14", "rx_ready after reset", rx_ready, 1);
        check(tx_valid === 1'b0, "R14", "tx_valid after reset", tx_valid, 0);
        check(led === 2'b00, "R14", "led after reset", led, 0);
        check(chan_codes === '0, "R14", "chan_codes after reset", chan_codes, 0);
        fr_q = {8'd255, 8'd22};                 run_frame("R14");
        // R1: stray low byte before a frame
        fr_q = {8'd5, 8'd255, 8'd25};           run_frame("R1");
        // R2/R4: write channel 1 with 0x1234, echo only
        fr_q = {8'd254, 8'd17, 8'd0, 8'd1, 8'd1, 8'd2, 8'd3, 8'd4}; run_frame("R2");
        fr_q = {8'd255, 8'd16, 8'd0, 8'd1};     run_frame("R4");
        fr_q = {8'd254, 8'd17, 8'd0, 8'd8, 8'd15, 8'd14, 8'd0, 8'd1}; run_frame("R6");
        fr_q = {8'd255, 8'd16, 8'd0, 8'd8};     run_frame("R5");
        // R3: foreign frame, then a normal one
        fr_q = {8'd130, 8'd17, 8'd0, 8'd2, 8'd15, 8'd15, 8'd15, 8'd15}; run_frame("R3");
        fr_q = {8'd130, 8'd40, 8'd255, 8'd21};  run_frame("R3");
        // R13: unknown command then status read twice
        fr_q = {8'd255, 8'd40};                 run_frame("R13");
        fr_q = {8'd255, 8'd21};                 run_frame("R10");
        fr_q = {8'd255, 8'd21};                 run_frame("R10");
        fr_q = {8'd255, 8'd16, 8'd0, 8'd9};     run_frame("R13");
        fr_q = {8'd255, 8'd17, 8'd16, 8'd255, 8'd21}; run_frame("R13");
        // R9: LEDs and an illegal value
        fr_q = {8'd255, 8'd20, 8'd15, 8'd15, 8'd0, 8'd0}; run_frame("R9");
        fr_q = {8'd255, 8'd20, 8'd0, 8'd5, 8'd15, 8'd15}; run_frame("R9");
        fr_q = {8'd255, 8'd21};                 run_frame("R10");
        // R11: rename, old name no longer matches
        fr_q = {8'd255, 8'd23, 8'd8, 8'd0};     run_frame("R11");
        fr_q = {8'd128, 8'd22};                 run_frame("R11");
        fr_q = {8'd254, 8'd22};                 run_frame("R11");
        fr_q = {8'd255, 8'd23, 8'd7, 8'd15};    run_frame("R11");
        fr_q = {8'd255, 8'd24};                 run_frame("R12");
        cfg_switch = 8'hA5;
        fr_q = {8'd255, 8'd19};                 run_frame("R8");
        fr_q = {8'd255, 8'd18};                 run_frame("R7");
        bp_en = 1'b1;
        for (int n = 0; n < 300; n++) rand_frame();
        done = 1'b1;
        finish_run();
    end

endmodule